// File: doc/BRIEF.md
# Low-Region Chip Select Decoder

This block drives an active-low chip select for a memory window anchored at address zero. Software sets the window size to a power of two of at least 4 KB. It does this by choosing which of the address lines A23 to A12 must be zero for a hit. Lines A31 to A24 must always be zero. Two byte-wide control registers hold this choice, together with a flag that makes the select also fire on refresh cycles. The registers are reached through a small register port that uses a one-bit index.

For a memory cycle, the address must fall inside the window and an external global enable must be set. A refresh cycle asserts the select whenever the refresh flag is set, whatever the global enable and the address. The normal setting is a run of ones from A23 downward followed by zeros. All twelve bits set gives 4 KB, and all clear gives 16 MB. The block also decodes any other pattern bit by bit, exactly as written. A build parameter chooses between a combinational select and a select registered on the clock.

Top module: `low_region_cs`

## Requirements
- R1: After reset, both registers read 0x00 (the high register resets to parameter HI_RST, 0x00 by default) and cs_no is 1.
- R2: A write with reg_we_i=1 updates the register chosen by reg_idx_i (0 = low register, 1 = high register) at the next rising clock edge. With reg_we_i=0 nothing changes. reg_rdata_o shows the chosen register while reg_re_i=1 and 0x00 otherwise.
- R3: Low register bits 3:1 always read as 0, whatever value was written to them.
- R4: Mask bit layout: low register bits 7:4 map to A15:A12, and high register bits 7:0 map to A23:A16. A mask bit of 1 requires its address line to be 0. A mask bit of 0 makes that line a don't-care.
- R5: A memory cycle never asserts the select if any of A31:A24 is 1.
- R6: A memory cycle never asserts the select while master_en_i is 0.
- R7: When low register bit 0 (refresh enable) is 1, rfsh_txn_i=1 asserts the select regardless of master_en_i and the address. When that bit is 0, a refresh cycle alone never asserts it.
- R8: With mem_txn_i=0 and rfsh_txn_i=0, cs_no is 1.
- R9: Mask patterns that are not contiguous are decoded bit by bit, without any correction.
- R10: With OUT_REG=0 (the default), cs_no follows its inputs in the same cycle. With OUT_REG=1, it follows them one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_idx_i | input | 1 | Register select: 0 low, 1 high |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, 0 when not reading |
| addr_i | input | 32 | Cycle address |
| mem_txn_i | input | 1 | Memory cycle in progress |
| rfsh_txn_i | input | 1 | Refresh cycle in progress |
| master_en_i | input | 1 | Global select enable |
| cs_no | output | 1 | Chip select, active low |

## Verification
A wrong mask bit, or a mask bit wired to the wrong address line, shows up as a select on an address just outside the window or a missing select just inside it. With the default build this is visible in the same cycle as the address. A stuck refresh flag shows on the first refresh cycle, in either direction. Register storage faults show on the read port on the cycle after the write. That includes a reserved bit that is kept when it should be dropped.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int REG_W    = 8;
  localparam int PAGE_LSB = 12;
  localparam int ZERO_LSB = 24;
  localparam int MASK_W   = ZERO_LSB - PAGE_LSB;
  localparam int LO_W     = 4;
  localparam int HI_W     = MASK_W - LO_W;

  typedef struct packed {
    logic [HI_W-1:0] mask_hi;
    logic [LO_W-1:0] mask_lo;
    logic            rfsh_en;
  } lrs_cfg_t;
endpackage

// File: rtl/lrs_regs.sv
module lrs_regs
  import lrs_pkg::*;
#(
  parameter logic [REG_W-1:0] HI_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output lrs_cfg_t         cfg_o
);
  lrs_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.mask_hi <= HI_RST;
      cfg_q.mask_lo <= '0;
      cfg_q.rfsh_en <= 1'b0;
    end else if (we_i) begin
      if (idx_i) begin
        cfg_q.mask_hi <= wdata_i;
      end else begin
        cfg_q.mask_lo <= wdata_i[REG_W-1 -: LO_W];
        cfg_q.rfsh_en <= wdata_i[0];
      end
    end
  end

  // reserved low-register bits are not stored and read as zero
  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (idx_i) rdata_o = cfg_q.mask_hi;
      else       rdata_o = {cfg_q.mask_lo, {(REG_W-LO_W-1){1'b0}}, cfg_q.rfsh_en};
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lrs_match.sv
module lrs_match
  import lrs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o
);
  logic [MASK_W-1:0] line_bad;
  logic              hi_zero;

  for (genvar i = 0; i < MASK_W; i++) begin : g_line
    assign line_bad[i] = mask_i[i] & addr_i[PAGE_LSB+i];
  end

  assign hi_zero = ~|addr_i[ADDR_W-1:ZERO_LSB];
  assign hit_o   = hi_zero & ~|line_bad;
endmodule

// File: rtl/low_region_cs.sv
module low_region_cs
  import lrs_pkg::*;
#(
  parameter int               ADDR_W  = 32,
  parameter logic [7:0]       HI_RST  = 8'h00,
  parameter bit               OUT_REG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_idx_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_txn_i,
  input  logic              rfsh_txn_i,
  input  logic              master_en_i,
  output logic              cs_no
);
  lrs_cfg_t          cfg;
  logic [MASK_W-1:0] mask;
  logic              addr_hit;
  logic              sel;
  logic              rfsh_en_w;

  lrs_regs #(.HI_RST(HI_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (reg_idx_i),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  assign mask      = {cfg.mask_hi, cfg.mask_lo};
  assign rfsh_en_w = cfg.rfsh_en;

  lrs_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i (addr_i),
    .mask_i (mask),
    .hit_o  (addr_hit)
  );

  // refresh path bypasses master enable and address
  assign sel = (mem_txn_i & master_en_i & addr_hit) | (rfsh_txn_i & rfsh_en_w);

  if (OUT_REG) begin : g_reg_out
    logic cs_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_q <= 1'b1;
      else         cs_q <= ~sel;
    end
    assign cs_no = cs_q;
  end else begin : g_comb_out
    assign cs_no = ~sel;
  end
endmodule

// File: rtl/low_region_cs_chk.sv
module low_region_cs_chk #(
  parameter int ADDR_W  = 32,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        reg_rdata_o,
  input logic [ADDR_W-1:0] addr_i,
  input logic              mem_txn_i,
  input logic              rfsh_txn_i,
  input logic              master_en_i,
  input logic              rfsh_en,
  input logic              cs_no
);
  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[3:1] == 3'b000);

  if (!OUT_REG) begin : g_comb
    // R8
    idle_deassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mem_txn_i && !rfsh_txn_i) |-> cs_no);
    // R5
    high_addr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rfsh_txn_i && (addr_i[ADDR_W-1:24] != '0)) |-> cs_no);
    // R6
    master_off_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rfsh_txn_i && !master_en_i) |-> cs_no);
    // R7
    rfsh_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rfsh_txn_i && rfsh_en) |-> !cs_no);
  end else begin : g_reg
    // R8
    idle_deassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mem_txn_i && !rfsh_txn_i) |=> cs_no);
    // R7
    rfsh_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rfsh_txn_i && rfsh_en) |=> !cs_no);
  end
endmodule

bind low_region_cs low_region_cs_chk #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rdata_o (reg_rdata_o),
  .addr_i      (addr_i),
  .mem_txn_i   (mem_txn_i),
  .rfsh_txn_i  (rfsh_txn_i),
  .master_en_i (master_en_i),
  .rfsh_en     (rfsh_en_w),
  .cs_no       (cs_no)
);

// File: tb/low_region_cs_tb_top.sv
module low_region_cs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_idx = 1'b0, reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] addr = '0;
  logic        mem_txn = 1'b0, rfsh_txn = 1'b0, master_en = 1'b0;
  logic        cs_n;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  low_region_cs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_idx_i(reg_idx), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .addr_i(addr), .mem_txn_i(mem_txn), .rfsh_txn_i(rfsh_txn),
    .master_en_i(master_en), .cs_no(cs_n)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [31:0] a;
    logic        mem;
    logic        rf;
    logic        men;
    logic        exp_n;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{"R4", 8'hF0, 8'hFF, 32'h0000_0FFF, 1'b1, 1'b0, 1'b1, 1'b0},
    '{"R4", 8'hF0, 8'hFF, 32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R4", 8'h00, 8'hFF, 32'h0000_F000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{"R4", 8'h00, 8'hFF, 32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R4", 8'h00, 8'h00, 32'h00FF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
    '{"R4", 8'h00, 8'hC0, 32'h003F_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
    '{"R4", 8'h00, 8'hC0, 32'h0040_0000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R5", 8'h00, 8'h00, 32'h0100_0000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R5", 8'h00, 8'h00, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R6", 8'h00, 8'h00, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{"R8", 8'h00, 8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1},
    '{"R8", 8'h01, 8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1},
    '{"R7", 8'h01, 8'hFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0},
    '{"R7", 8'h00, 8'h00, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b1},
    '{"R7", 8'hF1, 8'hFF, 32'h0001_0000, 1'b1, 1'b1, 1'b1, 1'b0},
    '{"R9", 8'h00, 8'h01, 32'h00FE_0000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{"R9", 8'h00, 8'h01, 32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R9", 8'h20, 8'h00, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b1},
    '{"R9", 8'h20, 8'h00, 32'h00FF_D000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{"R10",8'h00, 8'h80, 32'h0080_0000, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic idx, output logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_re = 1'b1;
    #1 d = reg_rdata;
    reg_re = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cs", {31'd0, cs_n}, 32'd1);
    rst_n = 1'b1;
    rd(1'b0, d); chk("R1 lo", {24'd0, d}, 32'h00);
    rd(1'b1, d); chk("R1 hi", {24'd0, d}, 32'h00);

    // R3: reserved bits dropped
    wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R3", {24'd0, d}, 32'hF1);
    wr(1'b0, 8'h0E);
    rd(1'b0, d); chk("R3 only rsvd", {24'd0, d}, 32'h00);

    // R2: write timing, index, read enable, no write without enable
    @(negedge clk);
    reg_idx = 1'b1; reg_we = 1'b1; reg_wdata = 8'h5A; reg_re = 1'b1;
    #1 chk("R2 before edge", {24'd0, reg_rdata}, 32'h00);
    @(negedge clk);
    reg_we = 1'b0;
    #1 chk("R2 after edge", {24'd0, reg_rdata}, 32'h5A);
    reg_re = 1'b0;
    #1 chk("R2 re low", {24'd0, reg_rdata}, 32'h00);
    rd(1'b0, d); chk("R2 other reg", {24'd0, d}, 32'h00);
    @(negedge clk);
    reg_idx = 1'b1; reg_wdata = 8'hA5;
    @(negedge clk);
    rd(1'b1, d); chk("R2 we low", {24'd0, d}, 32'h5A);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VECS[i].lo);
      wr(1'b1, VECS[i].hi);
      @(negedge clk);
      addr = VECS[i].a; mem_txn = VECS[i].mem;
      rfsh_txn = VECS[i].rf; master_en = VECS[i].men;
      #1 chk($sformatf("%s vec%0d", VECS[i].tag, i), {31'd0, cs_n}, {31'd0, VECS[i].exp_n});
      @(negedge clk);
      mem_txn = 1'b0; rfsh_txn = 1'b0;
    end

    // R10: combinational response within the same cycle
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    @(negedge clk);
    addr = 32'h0000_1234; master_en = 1'b1; mem_txn = 1'b1;
    #1 chk("R10 assert", {31'd0, cs_n}, 32'd0);
    mem_txn = 1'b0;
    #1 chk("R10 release", {31'd0, cs_n}, 32'd1);

    // R1: reset returns registers to default
    wr(1'b0, 8'hF1);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 rereset cs", {31'd0, cs_n}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, d); chk("R1 rereset lo", {24'd0, d}, 32'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule